// File: doc/BRIEF.md
# Segmented current-steering DAC input decoder

This block is the digital front end of a 14-bit current-steering converter split into a unary upper segment and a binary lower segment. Every clock it takes one straight-binary sample. The upper six bits are expanded into a 63-line thermometer code, one line per identical unit-current switch. The lower eight bits skip the decoder and pass through a path of matched delay that drives the binary-weighted switches. All 71 control lines are registered together, so every switch changes on the same rising edge.

The first stage is a level-sensitive latch that is open while the clock is low. The second stage is a rising-edge register. Decoding happens between the two, so a sample placed on the input during the low phase reaches the switches on the next rising edge, one clock of latency. Each control line has a true output and a complement output for differential steering. An active-high power-down input and an active-low reset each clear both stages at once, with no clock needed.

Top module: `segdac_frontend`

## Requirements
- R1: A sample held on `code_in` through the clock-low phase appears on the switch outputs after the next rising edge and is held until the following rising edge (one clock of latency).
- R2: Thermometer line k, which is `sw_p[k]` for k = 0..62, is high exactly when `code_in[13:8]` is greater than k. Upper bits 0 give no lines high. Upper bits 63 give all 63 lines high.
- R3: Binary lines `sw_p[70:63]` equal `code_in[7:0]`, with `sw_p[63+i]` carrying weight 2^i.
- R4: Changes on `code_in` while the clock is high do not affect the outputs before the next rising edge. Only the value present at the end of the low phase is taken.
- R5: Outside power-down and reset, `sw_n` is the bitwise complement of `sw_p`. A true line and its complement are never high together.
- R6: When `pwr_dn` is high, all `sw_p` lines go low and all `sw_n` lines go high at once, even with the clock stopped. The outputs stay there while `pwr_dn` is held, whatever `code_in` does.
- R7: When `rst_n` is low, the outputs are forced to the same cleared state as in R6, with no clock edge needed.
- R8: After `pwr_dn` and `rst_n` are both released, the first rising edge loads the sample taken in the preceding low phase.
- R9: The weighted value (number of thermometer lines high) × 256 + `sw_p[70:63]` equals the sample taken one cycle earlier, including the extremes 0 and 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock. Latch open while low, register loads on rise |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Asynchronous power-down, active high, works without a clock |
| code_in | input | 14 | Straight-binary input sample |
| sw_p | output | 71 | True switch controls: [62:0] thermometer, [70:63] binary |
| sw_n | output | 71 | Complement switch controls |

## Verification
The bench drives the thermometer boundaries: upper-bit values 0, 1, 62 and 63, the full-scale words 0 and 16383, and the carry points 255 and 256. A decoder that is off by one, or a line order that is reversed, fails at these values. It changes the input twice inside one low phase and once inside a high phase. A first stage built as an edge register or as an always-open path then shows the wrong sample or a change in the middle of a cycle. It also raises power-down with the clock stopped and then restarts the clock. A clear that waits for a clock edge leaves the outputs live, and a resume that takes an extra cycle shows up as a stale output on the first edge.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  // Unit segment k conducts when the segment code exceeds its index.
  function automatic logic unit_on(input int unsigned seg_code, input int unsigned k);
    return seg_code > k;
  endfunction

  // Weighted value of a switch pattern: units * 2^lsb_w + binary part.
  function automatic int unsigned weigh(input int unsigned units,
                                        input int unsigned bin_part,
                                        input int unsigned lsb_w);
    return (units << lsb_w) + bin_part;
  endfunction
endpackage

// File: rtl/segdac_in_latch.sv
module segdac_in_latch #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Open while the clock is low; cleared asynchronously.
  always_latch begin
    if (clr)       q <= '0;
    else if (!clk) q <= d;
  end
endmodule

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
  parameter int SEG_W = 6,
  localparam int UNITS = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0] seg,
  output logic [UNITS-1:0] therm
);
  import segdac_pkg::*;
  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    assign therm[k] = unit_on(int'(seg), k);
  end
endmodule

// File: rtl/segdac_lsb_align.sv
module segdac_lsb_align #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Pass-through chain standing in for the decoder's logic depth.
  logic [W-1:0] stg [DEPTH+1];
  assign stg[0] = d;
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    assign stg[i+1] = stg[i];
  end
  assign q = stg[DEPTH];
endmodule

// File: rtl/segdac_out_reg.sv
module segdac_out_reg #(
  parameter int N = 71
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N-1:0] d,
  output logic [N-1:0] q_p,
  output logic [N-1:0] q_n
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      q_p <= '0;
      q_n <= '1;
    end else begin
      q_p <= d;
      q_n <= ~d;
    end
  end
endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend #(
  parameter int SEG_W       = 6,
  parameter int LSB_W       = 8,
  parameter int ALIGN_DEPTH = 1,
  localparam int DATA_W = SEG_W + LSB_W,
  localparam int UNITS  = (1 << SEG_W) - 1,
  localparam int LINES  = UNITS + LSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic [DATA_W-1:0] code_in,
  output logic [LINES-1:0]  sw_p,
  output logic [LINES-1:0]  sw_n
);
  // Either shutdown source clears both stages without a clock.
  logic              clr_all;
  logic [DATA_W-1:0] held;
  logic [UNITS-1:0]  therm;
  logic [LSB_W-1:0]  lsb_al;
  logic [LINES-1:0]  pre_sw;

  assign clr_all = !rst_n || pwr_dn;

  segdac_in_latch #(.W(DATA_W)) u_latch (
    .clk(clk), .clr(clr_all), .d(code_in), .q(held)
  );

  segdac_therm_dec #(.SEG_W(SEG_W)) u_dec (
    .seg(held[DATA_W-1:LSB_W]), .therm(therm)
  );

  segdac_lsb_align #(.W(LSB_W), .DEPTH(ALIGN_DEPTH)) u_align (
    .d(held[LSB_W-1:0]), .q(lsb_al)
  );

  assign pre_sw = {lsb_al, therm};

  segdac_out_reg #(.N(LINES)) u_oreg (
    .clk(clk), .clr(clr_all), .d(pre_sw), .q_p(sw_p), .q_n(sw_n)
  );
endmodule

// File: rtl/segdac_frontend_chk.sv
module segdac_frontend_chk #(
  parameter int SEG_W = 6,
  parameter int LSB_W = 8,
  localparam int DATA_W = SEG_W + LSB_W,
  localparam int UNITS  = (1 << SEG_W) - 1,
  localparam int LINES  = UNITS + LSB_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic [DATA_W-1:0] code_in,
  input logic [LINES-1:0]  sw_p,
  input logic [LINES-1:0]  sw_n
);
  import segdac_pkg::*;

  // Shadow of the sample at each rising edge, voided by any shutdown.
  logic              settled;
  logic [DATA_W-1:0] shadow;
  logic              kill;
  logic [UNITS-1:0]  th_part;
  int unsigned       recon;

  assign kill    = !rst_n || pwr_dn;
  assign th_part = sw_p[UNITS-1:0];
  assign recon   = weigh($countones(th_part), int'(sw_p[LINES-1:UNITS]), LSB_W);

  always_ff @(posedge clk or posedge kill) begin
    if (kill) begin
      settled <= 1'b0;
      shadow  <= '0;
    end else begin
      settled <= 1'b1;
      shadow  <= code_in;
    end
  end

  // R1 / R9: the weighted output equals the sample from one edge earlier
  a_r9_recon_latency: assert property (@(posedge clk) disable iff (kill)
    settled |-> recon == int'(shadow));

  // R2: the lines that are on form a contiguous run from line 0
  a_r2_therm_shape: assert property (@(posedge clk) disable iff (kill)
    ((th_part + 1'b1) & th_part) == '0);

  // R5: a true line and its complement are never high together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_p & sw_n) == '0);

  // R6: while power-down is held the outputs sit in the cleared state
  a_r6_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (sw_p == '0 && sw_n == '1));

  // R7: the cleared state is present whenever reset is low at a falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r7_reset_clear: assert (sw_p == '0 && sw_n == '1);
    end
  end
endmodule

bind segdac_frontend segdac_frontend_chk #(.SEG_W(SEG_W), .LSB_W(LSB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
  .code_in(code_in), .sw_p(sw_p), .sw_n(sw_n)
);

// File: tb/segdac_frontend_tb.sv
module segdac_frontend_tb;
  localparam int NL = 71;

  logic          clk = 1'b0;
  logic          clk_run = 1'b1;
  logic          rst_n = 1'b1;
  logic          pwr_dn = 1'b0;
  logic [13:0]   code_in = '0;
  logic [NL-1:0] sw_p, sw_n;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  segdac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
    .code_in(code_in), .sw_p(sw_p), .sw_n(sw_n)
  );

  // 200 MHz clock that can be held low
  always begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  // Expected true bus: a run of ones for the upper part, then the raw low byte
  function automatic logic [NL-1:0] expect_bus(input logic [13:0] v);
    logic [NL-1:0] e;
    int unsigned   units;
    e = '0;
    units = v / 256;
    for (int i = 0; i < 63; i++) if (i < units) e[i] = 1'b1;
    for (int b = 0; b < 8; b++) e[63 + b] = v[b];
    return e;
  endfunction

  task automatic check_val(input logic [13:0] v, input string req);
    logic [NL-1:0] e;
    e = expect_bus(v);
    checks++;
    if (sw_p !== e || sw_n !== ~e) begin
      errors++;
      $display("FAIL %s: sw_p=%h sw_n=%h expected sw_p=%h sw_n=%h (sample %0d)",
               req, sw_p, sw_n, e, ~e, v);
    end
  endtask

  task automatic check_cleared(input string req);
    checks++;
    if (sw_p !== '0 || sw_n !== '1) begin
      errors++;
      $display("FAIL %s: sw_p=%h sw_n=%h expected sw_p=0 sw_n=all ones", req, sw_p, sw_n);
    end
  endtask

  // Drive v in the low phase; check it at the next falling edge.
  task automatic step(input logic [13:0] v, input string req);
    @(negedge clk);
    code_in = v;
    @(negedge clk);
    check_val(v, req);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] prev;
    void'($urandom(32'h5EED_D0AC));
    #1 rst_n = 1'b0;
    #1 check_cleared("R7 reset state");
    repeat (2) @(negedge clk);
    check_cleared("R7 reset held");
    code_in = 14'd777;
    rst_n = 1'b1;
    @(negedge clk);
    check_val(14'd777, "R8 first edge after reset");

    // Directed corner cases
    step(14'd0,     "R2 R9 zero");
    step(14'd16383, "R2 R9 full scale");
    step(14'd255,   "R3 low byte full");
    step(14'd256,   "R2 one unit");
    step(14'h3E00,  "R2 62 units");
    step(14'h3F00,  "R2 63 units");
    step(14'h00A5,  "R3 bit weights");

    // R1: back-to-back pipeline, each sample checked one cycle later
    @(negedge clk);
    code_in = 14'd1000;
    prev = 14'd1000;
    for (int n = 0; n < 400; n++) begin
      logic [13:0] v;
      v = 14'($urandom);
      @(negedge clk);
      check_val(prev, "R1 random stream");
      code_in = v;
      prev = v;
    end
    @(negedge clk);
    check_val(prev, "R1 random stream tail");

    // R4: only the end-of-low-phase value counts; high-phase change is held off
    @(negedge clk);
    code_in = 14'd300;
    #1 code_in = 14'd9000;
    @(posedge clk);
    #1 check_val(14'd9000, "R4 last low-phase value");
    code_in = 14'd12345;
    #1 check_val(14'd9000, "R4 high-phase change ignored");
    @(negedge clk);
    check_val(14'd9000, "R4 held to falling edge");
    @(negedge clk);
    check_val(14'd12345, "R4 taken next cycle");

    // R6: power-down with the clock stopped low
    @(negedge clk);
    code_in = 14'd4242;
    @(negedge clk);
    clk_run = 1'b0;
    #10 pwr_dn = 1'b1;
    #1 check_cleared("R6 clockless power-down");
    code_in = 14'd16000;
    #20 check_cleared("R6 held, input ignored");
    clk_run = 1'b1;
    repeat (3) @(negedge clk);
    check_cleared("R6 held with clock");
    code_in = 14'd5000;
    pwr_dn = 1'b0;
    @(negedge clk);
    check_val(14'd5000, "R8 first edge after power-down");

    // R7: reset in the middle of a run, then resume
    step(14'd8191, "R5 before reset");
    #1 rst_n = 1'b0;
    #1 check_cleared("R7 async reset mid-run");
    @(negedge clk);
    code_in = 14'd2;
    rst_n = 1'b1;
    @(negedge clk);
    check_val(14'd2, "R8 resume after mid-run reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule